// File: doc/BRIEF.md
# Constant Off-Time Gate Pulse Sequencer

This block produces the gate drive for a peak-current-mode LED buck converter that runs with a fixed off time and a variable on time. Each pulse rises, stays high until one of three events ends it, and then stays low for a programmed number of clock cycles. The three events are a trip of the normal current comparator, a trip of the overcurrent comparator, or expiry of a maximum on-time limit. When the low interval has elapsed, the next pulse starts at once.

Each comparator input is masked for its own leading-edge blanking window after the drive rises. The overcurrent window is shorter than the normal one, so a fast fault reaches the overcurrent path first. On the cycle the drive falls, the block emits a one-cycle strobe that names the event that ended the pulse, so that an external fault tracker can count max-on-time and overcurrent events.

An enable input stops switching while it is low. Comparators, timing resistors and the gate driver lie outside the block and appear only as clocked single-bit signals.

Top module: `cot_pulse_seq`

## Requirements
- R1: After synchronous reset, `drive_o` and all three strobes are 0, and they stay 0 for as long as `en_i` is low.
- R2: After a pulse ends, `drive_o` stays low for exactly max(`toff_cyc_i`, TOFF_MIN_CYC) cycles and then goes high. `toff_cyc_i` is sampled on the cycle the decision to end the pulse is taken.
- R3: Counting the first high cycle of a pulse as cycle 1, `cs_trip_i` is ignored in cycles 1 to BLANK_CYC. A trip sampled in high cycle n > BLANK_CYC makes n the last high cycle. A trip that is held high from the start therefore gives the minimum on time of BLANK_CYC+1 cycles.
- R4: `ovc_trip_i` is ignored in high cycles 1 to BLANK_OVC_CYC. A trip sampled in high cycle n > BLANK_OVC_CYC makes n the last high cycle.
- R5: If no unmasked trip occurs, the pulse lasts exactly TON_MAX_CYC high cycles and is reported as a timeout.
- R6: When several causes are present in the same cycle, the overcurrent trip takes priority over the normal trip, and the normal trip takes priority over the timeout. Exactly one cause is reported per pulse. Trips that arrive while the drive is low produce no strobe.
- R7: The strobes `ev_normal_o`, `ev_ovc_o` and `ev_tmax_o` are each one cycle wide. A strobe is high only in the first low cycle after the pulse it describes, and at most one of them is high in any cycle.
- R8: When `en_i` is sampled low, `drive_o` is low from the next cycle and no strobe is produced for the pulse that was cut short. When `en_i` is next sampled high, `drive_o` is high from the following cycle, with no off interval in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable / PWM dim input; low stops switching |
| toff_cyc_i | input | 16 | Requested off time in clock cycles |
| cs_trip_i | input | 1 | Digitised normal current-limit comparator |
| ovc_trip_i | input | 1 | Digitised overcurrent comparator |
| drive_o | output | 1 | Gate drive request |
| ev_normal_o | output | 1 | Strobe: pulse ended by the normal comparator |
| ev_ovc_o | output | 1 | Strobe: pulse ended by the overcurrent comparator |
| ev_tmax_o | output | 1 | Strobe: pulse ended by the max on-time limit |

## Verification
The bench builds the block with TON_MAX_CYC=20, BLANK_CYC=6, BLANK_OVC_CYC=3 and TOFF_MIN_CYC=4, in place of defaults sized for microsecond timing. These small values make every timeout pulse short. They also put the edges of both blanking windows, and the cases where a trip coincides with the timeout, within a few cycles of each other. Requested off times below, at and above the floor can then be checked in a few dozen cycles each.

// File: rtl/cot_pkg.sv
package cot_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        END_NONE   = 2'd0,
        END_NORMAL = 2'd1,
        END_OVC    = 2'd2,
        END_TMAX   = 2'd3
    } end_cause_t;

    typedef struct packed {
        logic normal;
        logic ovc;
        logic tmax;
    } strobe_t;

    localparam int TOFF_W = 16;

    // Raise a requested off time to the legal floor.
    function automatic logic [TOFF_W-1:0] clamp_toff(
        input logic [TOFF_W-1:0] req,
        input logic [TOFF_W-1:0] floor_v
    );
        return (req < floor_v) ? floor_v : req;
    endfunction

endpackage

// File: rtl/cot_blank_gate.sv
module cot_blank_gate #(
    parameter int CNT_W = 8,
    parameter int BLANK = 4
) (
    input  logic [CNT_W-1:0] age_i,
    input  logic             trip_i,
    output logic             qual_o
);
    // A trip counts only once the pulse is older than the window.
    assign qual_o = trip_i && (age_i > CNT_W'(BLANK));
endmodule

// File: rtl/cot_term_arb.sv
module cot_term_arb
    import cot_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int TON_MAX = 16
) (
    input  logic             on_phase_i,
    input  logic [CNT_W-1:0] age_i,
    input  logic             cs_ok_i,
    input  logic             ovc_ok_i,
    output end_cause_t       cause_o
);
    logic tmax_hit;
    assign tmax_hit = (age_i >= CNT_W'(TON_MAX));

    always_comb begin
        cause_o = END_NONE;
        if (on_phase_i) begin
            if (ovc_ok_i)      cause_o = END_OVC;
            else if (cs_ok_i)  cause_o = END_NORMAL;
            else if (tmax_hit) cause_o = END_TMAX;
        end
    end
endmodule

// File: rtl/cot_off_timer.sv
module cot_off_timer
    import cot_pkg::*;
#(
    parameter int TOFF_MIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [TOFF_W-1:0] toff_req_i,
    output logic              done_o
);
    localparam logic [TOFF_W-1:0] FLOOR = TOFF_W'(TOFF_MIN);

    logic [TOFF_W-1:0] remain;
    logic [TOFF_W-1:0] eff_len;

    assign eff_len = clamp_toff(toff_req_i, FLOOR);
    assign done_o  = (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load_i) begin
            remain <= eff_len - TOFF_W'(1);
        end else if (remain != '0) begin
            remain <= remain - TOFF_W'(1);
        end
    end

    // R2: a loaded interval never starts below the floor
    a_r2_floor_load: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (remain >= FLOOR - TOFF_W'(1)));
endmodule

// File: rtl/cot_pulse_seq.sv
module cot_pulse_seq
    import cot_pkg::*;
#(
    parameter int TON_MAX_CYC   = 4250,
    parameter int BLANK_CYC     = 68,
    parameter int BLANK_OVC_CYC = 28,
    parameter int TOFF_MIN_CYC  = 63
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_i,
    input  logic [15:0] toff_cyc_i,
    input  logic        cs_trip_i,
    input  logic        ovc_trip_i,
    output logic        drive_o,
    output logic        ev_normal_o,
    output logic        ev_ovc_o,
    output logic        ev_tmax_o
);
    localparam int CNT_W = $clog2(TON_MAX_CYC + 1);

    phase_t           phase;
    logic [CNT_W-1:0] on_cnt;
    strobe_t          strobe;
    logic             cs_ok, ovc_ok, off_done, end_now;
    end_cause_t       cause;

    cot_blank_gate #(.CNT_W(CNT_W), .BLANK(BLANK_CYC)) u_blank_norm (
        .age_i(on_cnt), .trip_i(cs_trip_i), .qual_o(cs_ok)
    );

    cot_blank_gate #(.CNT_W(CNT_W), .BLANK(BLANK_OVC_CYC)) u_blank_ovc (
        .age_i(on_cnt), .trip_i(ovc_trip_i), .qual_o(ovc_ok)
    );

    cot_term_arb #(.CNT_W(CNT_W), .TON_MAX(TON_MAX_CYC)) u_arb (
        .on_phase_i(phase == PH_ON), .age_i(on_cnt),
        .cs_ok_i(cs_ok), .ovc_ok_i(ovc_ok), .cause_o(cause)
    );

    assign end_now = en_i && (cause != END_NONE);

    cot_off_timer #(.TOFF_MIN(TOFF_MIN_CYC)) u_off (
        .clk(clk), .rst(rst), .load_i(end_now),
        .toff_req_i(toff_cyc_i), .done_o(off_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            on_cnt <= '0;
            strobe <= '0;
        end else begin
            strobe <= '0;
            unique case (phase)
                PH_IDLE: begin
                    if (en_i) begin
                        phase  <= PH_ON;
                        on_cnt <= CNT_W'(1);
                    end
                end
                PH_ON: begin
                    if (!en_i) begin
                        phase <= PH_IDLE;
                    end else if (end_now) begin
                        phase         <= PH_OFF;
                        strobe.normal <= (cause == END_NORMAL);
                        strobe.ovc    <= (cause == END_OVC);
                        strobe.tmax   <= (cause == END_TMAX);
                    end else begin
                        on_cnt <= on_cnt + CNT_W'(1);
                    end
                end
                PH_OFF: begin
                    if (!en_i) begin
                        phase <= PH_IDLE;
                    end else if (off_done) begin
                        phase  <= PH_ON;
                        on_cnt <= CNT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign drive_o     = (phase == PH_ON);
    assign ev_normal_o = strobe.normal;
    assign ev_ovc_o    = strobe.ovc;
    assign ev_tmax_o   = strobe.tmax;

    // R7: never two causes at once
    a_r7_one_cause: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_normal_o, ev_ovc_o, ev_tmax_o}));

    // R7: a strobe only accompanies a falling drive
    a_r7_strobe_on_fall: assert property (@(posedge clk) disable iff (rst)
        (ev_normal_o || ev_ovc_o || ev_tmax_o) |-> $fell(drive_o));

    // R3: normal end only after its blanking window
    a_r3_blank_norm: assert property (@(posedge clk) disable iff (rst)
        ev_normal_o |-> ($past(on_cnt) > CNT_W'(BLANK_CYC)));

    // R4: overcurrent end only after its blanking window
    a_r4_blank_ovc: assert property (@(posedge clk) disable iff (rst)
        ev_ovc_o |-> ($past(on_cnt) > CNT_W'(BLANK_OVC_CYC)));

    // R5: the on time never exceeds the limit
    a_r5_tmax_len: assert property (@(posedge clk) disable iff (rst)
        (drive_o && on_cnt == CNT_W'(TON_MAX_CYC)) |=> !drive_o);

    // R6: normal end is never reported over an unmasked overcurrent trip
    a_r6_ovc_first: assert property (@(posedge clk) disable iff (rst)
        ev_normal_o |-> !$past(ovc_ok));

    // R8: enable low stops the drive on the next cycle
    a_r8_dim_stop: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!drive_o && !ev_normal_o && !ev_ovc_o && !ev_tmax_o));
endmodule

// File: tb/cot_pulse_seq_test.sv
module cot_pulse_seq_test;
    localparam int TMAX  = 20;
    localparam int BLK   = 6;
    localparam int BLKO  = 3;
    localparam int TMIN  = 4;
    localparam int E_NONE = 0, E_NORM = 4, E_OVC = 2, E_TMAX = 1; // {normal,ovc,tmax}

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic [15:0] toff_cyc_i = 16'd12;
    logic        cs_trip_i = 1'b0;
    logic        ovc_trip_i = 1'b0;
    logic        drive_o, ev_normal_o, ev_ovc_o, ev_tmax_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cot_pulse_seq #(
        .TON_MAX_CYC(TMAX), .BLANK_CYC(BLK),
        .BLANK_OVC_CYC(BLKO), .TOFF_MIN_CYC(TMIN)
    ) uut (
        .clk(clk), .rst(rst), .en_i(en_i), .toff_cyc_i(toff_cyc_i),
        .cs_trip_i(cs_trip_i), .ovc_trip_i(ovc_trip_i), .drive_o(drive_o),
        .ev_normal_o(ev_normal_o), .ev_ovc_o(ev_ovc_o), .ev_tmax_o(ev_tmax_o)
    );

    function automatic int strobes();
        return {29'd0, ev_normal_o, ev_ovc_o, ev_tmax_o};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Enters at a negedge with drive just high (cycle 1); leaves at the
    // negedge where the next pulse is high.
    task automatic run_pulse(input string tag, input int cs_at, input int ovc_at,
                             input bit keep_cs, input int exp_on,
                             input int exp_ev, input int exp_off);
        int k = 1;
        int off = 1;
        bit stray = 1'b0;
        forever begin
            cs_trip_i  = (cs_at  != 0) && (k >= cs_at);
            ovc_trip_i = (ovc_at != 0) && (k >= ovc_at);
            @(negedge clk);
            if (!drive_o || k > 200) break;
            k++;
        end
        chk({tag, " on length"}, k, exp_on);
        chk({tag, " R7 end strobe"}, strobes(), exp_ev);
        cs_trip_i  = keep_cs;
        ovc_trip_i = 1'b0;
        forever begin
            @(negedge clk);
            if (drive_o || off > 200) break;
            if (strobes() != 0) stray = 1'b1;
            off++;
        end
        chk({tag, " R2 off length"}, off, exp_off);
        chk({tag, " R6 no strobe while low"}, int'(stray), 0);
    endtask

    task automatic reset_idle();
        bit bad = 1'b0;
        rst = 1'b1; en_i = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset drive", int'(drive_o), 0);
        chk("R1 reset strobes", strobes(), 0);
        repeat (6) begin
            @(negedge clk);
            if (drive_o || strobes() != 0) bad = 1'b1;
        end
        chk("R1 quiet while disabled", int'(bad), 0);
    endtask

    task automatic start_up();
        en_i = 1'b1;
        @(negedge clk);
        chk("R8 first pulse one cycle after enable", int'(drive_o), 1);
    endtask

    // Enters at negedge, drive high cycle 1; cuts the pulse after dim_k cycles.
    task automatic dim_cut(input int dim_k);
        bit bad = 1'b0;
        cs_trip_i = 1'b0; ovc_trip_i = 1'b0;
        repeat (dim_k - 1) @(negedge clk);
        chk("R8 still high before dim", int'(drive_o), 1);
        en_i = 1'b0;
        @(negedge clk);
        chk("R8 drive low after dim", int'(drive_o), 0);
        chk("R8 no strobe on cut pulse", strobes(), 0);
        repeat (5) begin
            @(negedge clk);
            if (drive_o || strobes() != 0) bad = 1'b1;
        end
        chk("R8 held low while dim low", int'(bad), 0);
        en_i = 1'b1;
        @(negedge clk);
        chk("R8 resume without off interval", int'(drive_o), 1);
    endtask

    initial begin
        reset_idle();
        start_up();
        toff_cyc_i = 16'd12;
        run_pulse("R3 normal trip at 10", 10, 0, 1'b0, 10, E_NORM, 12);
        run_pulse("R3 held trip min on", 1, 0, 1'b0, BLK + 1, E_NORM, 12);
        toff_cyc_i = 16'd1;
        run_pulse("R3 trip at blank edge", BLK, 0, 1'b0, BLK + 1, E_NORM, TMIN);
        toff_cyc_i = 16'd0;
        run_pulse("R4 ovc early", 1, 2, 1'b0, BLKO + 1, E_OVC, TMIN);
        toff_cyc_i = 16'd4;
        run_pulse("R4 ovc at blank edge", 0, BLKO, 1'b0, BLKO + 1, E_OVC, TMIN);
        run_pulse("R6 ovc beats normal", 8, 8, 1'b1, 8, E_OVC, 4);
        toff_cyc_i = 16'd5;
        run_pulse("R5 timeout", 0, 0, 1'b0, TMAX, E_TMAX, 5);
        toff_cyc_i = 16'd6;
        run_pulse("R6 ovc beats timeout", 0, TMAX, 1'b0, TMAX, E_OVC, 6);
        run_pulse("R6 normal beats timeout", TMAX, 0, 1'b0, TMAX, E_NORM, 6);
        dim_cut(5);
        toff_cyc_i = 16'd9;
        run_pulse("R8 after resume", 9, 0, 1'b0, 9, E_NORM, 9);
        chk("R1 unused none code", E_NONE, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule